// File: doc/BRIEF.md
# Two-Parity Reed-Solomon Single-Error Corrector

This block decodes one Reed-Solomon codeword over GF(2^8) that carries two parity symbols. Symbols arrive one per accepted cycle, and the block accumulates two syndromes as they arrive. The field is generated by x^8+x^4+x^3+x^2+1, and alpha is 0x02. Two code lengths are supported. The short shape is 26 symbols (24 data plus 2 parity), used on matrix columns. The long shape is 45 symbols (43 data plus 2 parity), used on diagonals.

When the last symbol has been accepted, the block classifies the word into one of three outcomes: error-free, one correctable error, or uncorrectable. For a single error it reports the error position and the error value. It finds them by solving the two syndrome equations directly. The value is S0, and the position is the discrete log of S1/S0, taken from a log table built at elaboration. Collecting symbols from a sector, iterating between rows and columns, and writing corrections back are left to the surrounding logic.

Top module: `rs2_corrector`

## Requirements
- R1: After a synchronous active-low reset, and until a word completes, res_valid is 0, res_status is 2'b00, and err_pos and err_val are 0.
- R2: res_valid is a single-cycle pulse. It rises exactly one clock after the cycle that accepts a symbol with sym_last set, and it is never high at any other time.
- R3: When both syndromes are zero, res_status is 2'b00 (clean), and err_pos and err_val are 0. The code 2'b11 never appears.
- R4: A codeword with exactly one corrupted symbol gives res_status 2'b01 (corrected). err_val is the XOR difference at that symbol. err_pos is its power index: 0 is the last symbol streamed and length-1 is the first.
- R5: When S0 (the XOR of all symbols) is zero and S1 is nonzero, res_status is 2'b10 (failed).
- R6: When S0 is nonzero and S1 is zero, res_status is 2'b10.
- R7: When the solved position is greater than or equal to the selected code length, res_status is 2'b10. In every non-corrected outcome, err_pos and err_val are 0.
- R8: len_sel is sampled only with the first symbol (0 selects 26 symbols, 1 selects 45). Changes to it later in the word have no effect.
- R9: Cycles with sym_valid low between symbols do not change the outcome.
- R10: A symbol with sym_first set restarts accumulation and discards any partial word that came before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| len_sel | input | 1 | Code length select, sampled with the first symbol |
| sym_valid | input | 1 | Symbol present this cycle |
| sym_first | input | 1 | Marks the first symbol of a word |
| sym_last | input | 1 | Marks the last symbol of a word |
| sym_data | input | 8 | Symbol, highest power first |
| res_valid | output | 1 | Result pulse |
| res_status | output | 2 | 00 clean, 01 corrected, 10 failed |
| err_pos | output | 6 | Power index of the corrected symbol |
| err_val | output | 8 | Value to XOR into that symbol |

## Verification
The hardest outcome to reach is R7, a nonzero syndrome pair whose quotient is a valid power of alpha that lies outside the short word. No single error inside a 26-symbol word can produce it. The bench therefore searches two-error patterns on the two lowest positions until the brute-force solution lands at or above 26, and then sends that word in short mode. Parity for the clean codewords is found by exhaustive search over the second parity symbol. Throughout the run, len_sel is flipped after the first symbol, and stall cycles are placed between symbols.

// File: rtl/rs2_pkg.sv
// Shared field arithmetic and result codes for the two-parity RS corrector.
// Assumes GF(2^8) with generator x^8+x^4+x^3+x^2+1 and alpha = 0x02.
package rs2_pkg;
    localparam int          SYM_W    = 8;
    localparam logic [7:0]  POLY_LOW = 8'h1D;

    typedef enum logic [1:0] {
        ST_OK    = 2'b00,
        ST_FIXED = 2'b01,
        ST_FAIL  = 2'b10
    } rs_stat_e;

    typedef logic [255:0][7:0] gf_tab_t;

    // Multiply a field element by alpha.
    function automatic logic [7:0] gf_mul_alpha(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? POLY_LOW : 8'h00);
    endfunction

    // Discrete log table; entry 0 is unused and left at zero.
    function automatic gf_tab_t gf_log_tab();
        gf_tab_t    t;
        logic [7:0] v;
        t = '0;
        v = 8'h01;
        for (int i = 0; i < 255; i++) begin
            t[v] = i[7:0];
            v    = gf_mul_alpha(v);
        end
        return t;
    endfunction
endpackage

// File: rtl/rs2_syndrome.sv
// Syndrome accumulator: S0 is the XOR of all symbols, and S1 is built by
// Horner's rule (S1*alpha ^ symbol). Symbols arrive highest power first.
// The next values are also driven out combinationally, so the top can
// register a verdict in the same cycle as the last symbol.
module rs2_syndrome
    import rs2_pkg::*;
#(
    parameter int W = SYM_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sym_valid,
    input  logic         sym_first,
    input  logic [W-1:0] sym_data,
    output logic [W-1:0] s0_nxt,
    output logic [W-1:0] s1_nxt
);
    logic [W-1:0] s0_q;
    logic [W-1:0] s1_q;

    // Next syndrome values, restarting on the first symbol.
    always_comb begin
        if (sym_first) begin
            s0_nxt = sym_data;
            s1_nxt = sym_data;
        end else begin
            s0_nxt = s0_q ^ sym_data;
            s1_nxt = gf_mul_alpha(s1_q) ^ sym_data;
        end
    end

    // Hold the syndromes between accepted symbols.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s0_q <= '0;
            s1_q <= '0;
        end else if (sym_valid) begin
            s0_q <= s0_nxt;
            s1_q <= s1_nxt;
        end
    end

    AST_S0_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_first) |=> (s0_q == $past(sym_data))) else $error("restart"); // R10
    AST_S1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid |=> $stable(s1_q)) else $error("stall"); // R9
endmodule

// File: rtl/rs2_locator.sv
// Single-error solver: from (S0, S1) it decides clean, corrected or failed.
// The value is S0, and the position is log(S1) - log(S0) mod 255.
// Assumes code_len is at most 255. Purely combinational.
module rs2_locator
    import rs2_pkg::*;
#(
    parameter int POS_W = 6
) (
    input  logic [7:0]       s0,
    input  logic [7:0]       s1,
    input  logic [POS_W-1:0] code_len,
    output rs_stat_e         status,
    output logic [POS_W-1:0] pos,
    output logic [7:0]       val
);
    localparam gf_tab_t LOG_T = gf_log_tab();

    logic [7:0] l0;
    logic [7:0] l1;
    logic [8:0] diff;

    // Log lookup and modular difference of exponents.
    always_comb begin
        l0 = LOG_T[s0];
        l1 = LOG_T[s1];
        if (l1 >= l0) diff = {1'b0, l1} - {1'b0, l0};
        else          diff = {1'b0, l1} + 9'd255 - {1'b0, l0};
    end

    // Classification of the syndrome pair.
    always_comb begin
        status = ST_FAIL;
        pos    = '0;
        val    = '0;
        if (s0 == 8'h00 && s1 == 8'h00) begin
            status = ST_OK;
        end else if (s0 != 8'h00 && s1 != 8'h00 && diff < 9'(code_len)) begin
            status = ST_FIXED;
            pos    = diff[POS_W-1:0];
            val    = s0;
        end
    end
endmodule

// File: rtl/rs2_corrector.sv
// Top of the two-parity RS single-error corrector. It latches the code
// length with the first symbol, feeds the syndrome accumulator, and
// registers the verdict on the last symbol as a one-cycle result pulse.
// Assumes words are framed by sym_first/sym_last and hold at least two symbols.
module rs2_corrector
    import rs2_pkg::*;
#(
    parameter int LEN_SHORT = 26,
    parameter int LEN_LONG  = 45,
    parameter int POS_W     = $clog2(LEN_LONG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             len_sel,
    input  logic             sym_valid,
    input  logic             sym_first,
    input  logic             sym_last,
    input  logic [7:0]       sym_data,
    output logic             res_valid,
    output logic [1:0]       res_status,
    output logic [POS_W-1:0] err_pos,
    output logic [7:0]       err_val
);
    localparam logic [POS_W-1:0] L_SHORT = POS_W'(LEN_SHORT);
    localparam logic [POS_W-1:0] L_LONG  = POS_W'(LEN_LONG);

    logic [POS_W-1:0] len_q;
    logic [POS_W-1:0] len_cur;
    logic [7:0]       s0_nxt;
    logic [7:0]       s1_nxt;
    rs_stat_e         dec_stat;
    logic [POS_W-1:0] dec_pos;
    logic [7:0]       dec_val;

    // Length in force: freshly selected on the first symbol, else latched.
    always_comb begin
        if (sym_first) len_cur = len_sel ? L_LONG : L_SHORT;
        else           len_cur = len_q;
    end

    // Latch the length when a word starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                      len_q <= L_SHORT;
        else if (sym_valid && sym_first) len_q <= len_cur;
    end

    rs2_syndrome #(.W(8)) u_syn (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .sym_first (sym_first),
        .sym_data  (sym_data),
        .s0_nxt    (s0_nxt),
        .s1_nxt    (s1_nxt)
    );

    rs2_locator #(.POS_W(POS_W)) u_loc (
        .s0       (s0_nxt),
        .s1       (s1_nxt),
        .code_len (len_cur),
        .status   (dec_stat),
        .pos      (dec_pos),
        .val      (dec_val)
    );

    // Register the verdict on the last symbol; pulse valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_status <= ST_OK;
            err_pos    <= '0;
            err_val    <= '0;
        end else begin
            res_valid <= sym_valid && sym_last;
            if (sym_valid && sym_last) begin
                res_status <= dec_stat;
                err_pos    <= dec_pos;
                err_val    <= dec_val;
            end
        end
    end

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid) else $error("pulse"); // R2
    AST_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(sym_valid && sym_last)) else $error("cause"); // R2
    AST_NO_CODE3: assert property (@(posedge clk) disable iff (!rst_n)
        res_status != 2'b11) else $error("code"); // R3
    AST_FIX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == ST_FIXED) |-> (err_val != 8'h00 && err_pos < len_q)) else $error("range"); // R4
    AST_FAIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status != ST_FIXED) |-> (err_val == 8'h00 && err_pos == '0)) else $error("clear"); // R7
endmodule

// File: tb/rs2_corrector_test.sv
// Self-checking bench: a table of word recipes walked by one loop, then
// directed cases for reset, restart and out-of-range position.
module rs2_corrector_test;
    typedef struct packed {
        logic       sel;
        logic [7:0] seed;
        logic [1:0] nerr;
        logic [5:0] p1;
        logic [7:0] v1;
        logic [5:0] p2;
        logic [7:0] v2;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 8'h11, 2'd0, 6'd0,  8'h00, 6'd0,  8'h00},  // R3
        '{1'b1, 8'h5A, 2'd0, 6'd0,  8'h00, 6'd0,  8'h00},  // R3 R8
        '{1'b0, 8'h23, 2'd1, 6'd0,  8'h01, 6'd0,  8'h00},  // R4
        '{1'b0, 8'h9C, 2'd1, 6'd25, 8'hFF, 6'd0,  8'h00},  // R4
        '{1'b1, 8'h47, 2'd1, 6'd44, 8'h80, 6'd0,  8'h00},  // R4 R8
        '{1'b1, 8'h3E, 2'd1, 6'd30, 8'h5A, 6'd0,  8'h00},  // R4 R8
        '{1'b0, 8'h71, 2'd2, 6'd3,  8'hAA, 6'd9,  8'hAA},  // R5
        '{1'b1, 8'h02, 2'd2, 6'd0,  8'h02, 6'd1,  8'h01},  // R6
        '{1'b1, 8'h88, 2'd2, 6'd10, 8'h13, 6'd40, 8'hC4},  // mixed
        '{1'b0, 8'hE0, 2'd1, 6'd12, 8'h37, 6'd0,  8'h00}   // R4
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       len_sel = 1'b0;
    logic       sym_valid = 1'b0;
    logic       sym_first = 1'b0;
    logic       sym_last = 1'b0;
    logic [7:0] sym_data = 8'h00;
    logic       res_valid;
    logic [1:0] res_status;
    logic [5:0] err_pos;
    logic [7:0] err_val;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] w [45];
    logic [1:0] e_stat;
    logic [5:0] e_pos;
    logic [7:0] e_val;

    always #4 clk = ~clk;

    rs2_corrector uut (
        .clk(clk), .rst_n(rst_n), .len_sel(len_sel), .sym_valid(sym_valid),
        .sym_first(sym_first), .sym_last(sym_last), .sym_data(sym_data),
        .res_valid(res_valid), .res_status(res_status),
        .err_pos(err_pos), .err_val(err_val)
    );

    function automatic logic [7:0] ma(input logic [7:0] a);
        return a[7] ? ((a << 1) ^ 8'h1D) : (a << 1);
    endfunction

    // Brute-force exponent k with s0*alpha^k == s1; 255 when none exists.
    function automatic int find_pow(input logic [7:0] s0, input logic [7:0] s1);
        logic [7:0] t = s0;
        for (int k = 0; k < 255; k++) begin
            if (t == s1) return k;
            t = ma(t);
        end
        return 255;
    endfunction

    // Expected outcome for word w of length n.
    task automatic expect_word(input int n);
        logic [7:0] s0 = 8'h00;
        logic [7:0] s1 = 8'h00;
        int k;
        for (int i = 0; i < n; i++) begin
            s0 = s0 ^ w[i];
            s1 = ma(s1) ^ w[i];
        end
        e_pos = 6'd0;
        e_val = 8'h00;
        if (s0 == 8'h00 && s1 == 8'h00) e_stat = 2'd0;
        else if (s0 == 8'h00) e_stat = 2'd2;
        else begin
            k = find_pow(s0, s1);
            if (k < n && s1 != 8'h00) begin
                e_stat = 2'd1;
                e_pos  = 6'(k);
                e_val  = s0;
            end else e_stat = 2'd2;
        end
    endtask

    // Build a valid codeword of length n from a seed.
    task automatic build_code(input int n, input logic [7:0] seed);
        logic [7:0] d = seed;
        logic [7:0] a = 8'h00;
        logic [7:0] b = 8'h00;
        for (int i = 0; i < n - 2; i++) begin
            w[i] = d;
            d = d * 8'd5 + 8'd7;
            a = a ^ w[i];
            b = ma(b) ^ w[i];
        end
        b = ma(ma(b));
        for (int c = 0; c < 256; c++) begin
            if (((a ^ 8'(c)) ^ ma(8'(c))) == b) begin
                w[n-2] = 8'(c);
                w[n-1] = a ^ 8'(c);
            end
        end
    endtask

    // Stream w[0..n-1]; len_sel flips after the first symbol.
    task automatic send_word(input logic sel, input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (gaps && (i % 3 == 2)) begin
                sym_valid = 1'b0;
                @(negedge clk);
            end
            sym_valid = 1'b1;
            sym_first = (i == 0);
            sym_last  = (i == n - 1);
            sym_data  = w[i];
            len_sel   = (i == 0) ? sel : ~sel;
        end
        @(negedge clk);
        sym_valid = 1'b0;
        sym_first = 1'b0;
        sym_last  = 1'b0;
    endtask

    task automatic check_res(input string req);
        checks++;
        if (res_valid !== 1'b1 || res_status !== e_stat || err_pos !== e_pos || err_val !== e_val) begin
            errors++;
            $display("FAIL %s: got v=%0b st=%0d pos=%0d val=%h, exp v=1 st=%0d pos=%0d val=%h",
                     req, res_valid, res_status, err_pos, err_val, e_stat, e_pos, e_val);
        end
    endtask

    task automatic check_idle(input string req);
        checks++;
        if (res_valid !== 1'b0) begin
            errors++;
            $display("FAIL %s: res_valid got %0b exp 0", req, res_valid);
        end
    endtask

    initial begin
        int n;
        int e1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (res_valid !== 1'b0 || res_status !== 2'd0 || err_pos !== 6'd0 || err_val !== 8'h00) begin
            errors++;
            $display("FAIL R1: got v=%0b st=%0d pos=%0d val=%h exp 0 0 0 00",
                     res_valid, res_status, err_pos, err_val);
        end

        // Table walk (R3 R4 R5 R6 R8 R9; stalls on odd entries)
        for (int v = 0; v < NVEC; v++) begin
            n = VEC[v].sel ? 45 : 26;
            build_code(n, VEC[v].seed);
            if (VEC[v].nerr >= 2'd1) w[n-1-int'(VEC[v].p1)] ^= VEC[v].v1;
            if (VEC[v].nerr == 2'd2) w[n-1-int'(VEC[v].p2)] ^= VEC[v].v2;
            expect_word(n);
            if (VEC[v].nerr == 2'd1) begin
                e_stat = 2'd1;
                e_pos  = VEC[v].p1;
                e_val  = VEC[v].v1;
            end
            send_word(VEC[v].sel, n, v[0]);
            check_res($sformatf("R4/R5/R6/R8/R9 vec %0d", v));
            @(negedge clk);
            check_idle("R2 pulse width");
        end

        // R7: two errors on the lowest positions whose solution lands at 26 or above
        e1 = 3;
        while (e1 < 256 && !(find_pow(8'(e1) ^ 8'h01, 8'(e1) ^ 8'h02) >= 26 &&
                             find_pow(8'(e1) ^ 8'h01, 8'(e1) ^ 8'h02) < 255)) e1++;
        for (int i = 0; i < 26; i++) w[i] = 8'h00;
        w[25] = 8'(e1);
        w[24] = 8'h01;
        e_stat = 2'd2; e_pos = 6'd0; e_val = 8'h00;
        send_word(1'b0, 26, 1'b0);
        check_res("R7 position beyond short length");

        // Same pattern in long mode corrects when the position is below 45
        for (int i = 0; i < 45; i++) w[i] = 8'h00;
        w[44] = 8'(e1);
        w[43] = 8'h01;
        expect_word(45);
        send_word(1'b1, 45, 1'b0);
        check_res("R8 long mode same pattern");

        // R10: abandoned partial word followed by a fresh single-error word
        for (int i = 0; i < 10; i++) w[i] = 8'(i * 37 + 5);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            sym_valid = 1'b1; sym_first = (i == 0); sym_last = 1'b0; sym_data = w[i];
        end
        check_idle("R2 no pulse mid-word");
        build_code(26, 8'h4D);
        w[26-1-7] ^= 8'h9E;
        e_stat = 2'd1; e_pos = 6'd7; e_val = 8'h9E;
        send_word(1'b0, 26, 1'b0);
        check_res("R10 restart on first");

        // R1: reset in the middle of a word clears the outputs
        build_code(26, 8'h17);
        w[0] ^= 8'h01;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            sym_valid = 1'b1; sym_first = (i == 0); sym_last = 1'b0; sym_data = w[i];
        end
        rst_n = 1'b0;
        @(negedge clk);
        sym_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_status !== 2'd0 || err_pos !== 6'd0 || err_val !== 8'h00) begin
            errors++;
            $display("FAIL R1 mid-word reset: got v=%0b st=%0d pos=%0d val=%h exp 0 0 0 00",
                     res_valid, res_status, err_pos, err_val);
        end

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule